// File: doc/BRIEF.md
# Serial Voltage-ID Command Controller

This block is the digital front end of a dual-plane regulator controller. When `enable` goes high it reads one shared pin (`par_vid[1]`) once to choose its operating mode. In parallel mode, plane 1 follows six parallel code pins and plane 2's output stage is told to float. In serial mode, both planes first take a start-up code chosen by the two bus pins. If power-good is low at enable, that start-up code is a boot value. The boot value is stored and reapplied whenever power-good drops later. If power-good is already high at enable, the start-up code is a fixed value and the bus is never served.

Once power-good is high in boot-started serial mode, a two-wire receiver accepts framed commands. A frame carries an address byte and then a data byte. The address selects plane 1, plane 2 or both. The data byte supplies a power-save-low flag and a 7-bit voltage code. The bus pins are sampled by the system clock, and edges of the serial clock line are detected from those samples.

Top module: `svid_ctrl`

## Requirements
- R1: While `enable` is low, both plane codes are 0, `plane2_hiz` and `psi_low` are 1, `serial_mode` and `sda_pull_low` are 0; all outputs are registered.
- R2: On the clock that first sees `enable` high, `par_vid[1]` is sampled: 0 gives `serial_mode`=1 and 1 gives `serial_mode`=0. Later changes on that pin have no effect until `enable` falls.
- R3: In parallel mode, `plane1_code` = {0, `par_vid`} one clock after the pins, `plane2_code` is 0, `plane2_hiz` is 1, and the bus is never acknowledged.
- R4: In serial mode with `pwr_good` low at enable, the code {`scl`,`sda`} (scl is bit 1) is stored and both planes take BOOT_TABLE[code]. Defaults are 0→0x12, 1→0x24, 2→0x36, 3→0x48. `plane2_hiz` is 0.
- R5: While enabled in boot-started serial mode, a falling `pwr_good` returns both planes to the stored boot entry, sets `psi_low` to 1 and abandons any frame in progress.
- R6: Bus traffic while `pwr_good` is low is not acknowledged and changes no output.
- R7: In serial mode with `pwr_good` high at enable, both planes take FIX_TABLE[{`scl`,`sda`}]. Defaults are 0→0x2D, 1→0x3C, 2→0x4B, 3→0x5A. The bus is never served, and a later `pwr_good` fall changes nothing.
- R8: A frame is a start (sda falls while scl high), an 8-bit address, an acknowledge, an 8-bit data byte and an acknowledge, ending with a stop (sda rises while scl high). Bits are taken MSB first on scl rising edges. Each acknowledge asserts `sda_pull_low` from the falling scl edge after the eighth bit to the falling edge after the ninth.
- R9: The address byte is {5'b11000, sel}. sel 3'b110 targets plane 1, 3'b101 targets plane 2 and 3'b111 targets both. Any other address is not acknowledged and changes nothing.
- R10: Data bit 7 goes to `psi_low`, and bits 6:0 go to the addressed plane code or codes.
- R11: Outputs update only once the ninth clock of the data byte is seen. A frame cut short by a stop or a new start leaves every output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Controller enable |
| pwr_good | input | 1 | Power-good indication |
| scl | input | 1 | Serial clock line |
| sda | input | 1 | Serial data line (as seen on the wire) |
| par_vid | input | 6 | Parallel voltage code; bit 1 also selects the mode at enable |
| sda_pull_low | output | 1 | Drives the data line low for an acknowledge |
| plane1_code | output | 7 | Voltage code for plane 1 |
| plane2_code | output | 7 | Voltage code for plane 2 |
| psi_low | output | 1 | Power-save-low flag |
| serial_mode | output | 1 | 1 in serial dual-plane mode |
| plane2_hiz | output | 1 | Floats the plane-2 output stage |

## Verification
The bench targets the start-up choices. It flips the shared mode pin after enable, and a design that kept sampling it would switch modes partway through operation. It uses two different boot codes, so swapped scl/sda bit order shows up as the wrong table entry. It drops power-good both in boot mode and in fixed mode: a missing replay, or a replay in fixed mode, changes the plane codes. It also sends frames before power-good, with a bad prefix, with an unlisted select value, and cut off after five data bits. A receiver that acknowledged too freely, or that committed partial data, would drive the acknowledge or move an output where the reference model does not.

// File: rtl/svid_pkg.sv
package svid_pkg;

    localparam int CODE_W = 7;
    localparam int BYTE_W = 8;
    localparam int SEL_W  = 3;
    localparam int CNT_W  = $clog2(BYTE_W + 1);

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_ADDR,
        RX_AACK,
        RX_DATA,
        RX_DACK,
        RX_HOLD
    } rx_state_e;

    typedef struct packed {
        rx_state_e          state;
        logic [CNT_W-1:0]   cnt;
        logic [BYTE_W-1:0]  shreg;
        logic [1:0]         tgt;      // bit0 plane 1, bit1 plane 2
        logic               ack;
        logic               cmd_valid;
        logic               scl_q;
        logic               sda_q;
    } rx_t;

    typedef struct packed {
        logic               en_q;
        logic               serial_q;
        logic               fixed_q;
        logic [1:0]         boot_q;
        logic               listen_q;
        logic               pg_q;
        logic [CODE_W-1:0]  p1;
        logic [CODE_W-1:0]  p2;
        logic               psi;
        logic               hiz;
    } ctl_t;

endpackage

// File: rtl/svid_link_rx.sv
module svid_link_rx
    import svid_pkg::*;
#(
    parameter logic [BYTE_W-SEL_W-1:0] ADDR_PREFIX = 5'b11000,
    parameter logic [SEL_W-1:0]        SEL_P1      = 3'b110,
    parameter logic [SEL_W-1:0]        SEL_P2      = 3'b101,
    parameter logic [SEL_W-1:0]        SEL_BOTH    = 3'b111
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic              scl,
    input  logic              sda,
    output logic              sda_pull_low,
    output logic              cmd_valid,
    output logic [1:0]        cmd_tgt,
    output logic [BYTE_W-1:0] cmd_byte
);

    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

    localparam rx_t RX_RST = '{
        state: RX_IDLE, cnt: '0, shreg: '0, tgt: 2'b00,
        ack: 1'b0, cmd_valid: 1'b0, scl_q: 1'b1, sda_q: 1'b1
    };

    rx_t q, d;

    logic              rise_c, fall_c, start_c, stop_c;
    logic [BYTE_W-1:0] shifted;
    logic [1:0]        dec_tgt;

    always_comb begin
        rise_c  = scl & ~q.scl_q;
        fall_c  = ~scl & q.scl_q;
        start_c = scl & q.scl_q & q.sda_q & ~sda;
        stop_c  = scl & q.scl_q & ~q.sda_q & sda;
        shifted = {q.shreg[BYTE_W-2:0], sda};

        dec_tgt = 2'b00;
        if (shifted[BYTE_W-1:SEL_W] == ADDR_PREFIX) begin
            if (shifted[SEL_W-1:0] == SEL_P1)        dec_tgt = 2'b01;
            else if (shifted[SEL_W-1:0] == SEL_P2)   dec_tgt = 2'b10;
            else if (shifted[SEL_W-1:0] == SEL_BOTH) dec_tgt = 2'b11;
        end

        d           = q;
        d.cmd_valid = 1'b0;
        d.scl_q     = scl;
        d.sda_q     = sda;

        if (!active) begin
            d.state = RX_IDLE;
            d.ack   = 1'b0;
        end else if (start_c) begin
            d.state = RX_ADDR;
            d.cnt   = '0;
            d.ack   = 1'b0;
        end else if (stop_c) begin
            d.state = RX_IDLE;
            d.ack   = 1'b0;
        end else begin
            case (q.state)
                RX_ADDR: if (rise_c) begin
                    d.shreg = shifted;
                    d.cnt   = q.cnt + 1'b1;
                    if (q.cnt == LAST_BIT) begin
                        if (dec_tgt != 2'b00) begin
                            d.tgt   = dec_tgt;
                            d.state = RX_AACK;
                        end else begin
                            d.state = RX_IDLE;
                        end
                    end
                end
                RX_AACK: if (fall_c) begin
                    if (!q.ack) begin
                        d.ack = 1'b1;
                    end else begin
                        d.ack   = 1'b0;
                        d.state = RX_DATA;
                        d.cnt   = '0;
                    end
                end
                RX_DATA: if (rise_c) begin
                    d.shreg = shifted;
                    d.cnt   = q.cnt + 1'b1;
                    if (q.cnt == LAST_BIT) d.state = RX_DACK;
                end
                RX_DACK: begin
                    if (fall_c && !q.ack) begin
                        d.ack = 1'b1;
                    end else if (rise_c && q.ack) begin
                        d.cmd_valid = 1'b1;
                    end else if (fall_c && q.ack) begin
                        d.ack   = 1'b0;
                        d.state = RX_HOLD;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= RX_RST;
        else        q <= d;
    end

    assign sda_pull_low = q.ack;
    assign cmd_valid    = q.cmd_valid;
    assign cmd_tgt      = q.tgt;
    assign cmd_byte     = q.shreg;

endmodule

// File: rtl/svid_plane_ctrl.sv
module svid_plane_ctrl
    import svid_pkg::*;
#(
    parameter int                    PAR_W       = 6,
    parameter logic [4*CODE_W-1:0]   BOOT_TABLE  = {7'h48, 7'h36, 7'h24, 7'h12},
    parameter logic [4*CODE_W-1:0]   FIX_TABLE   = {7'h5A, 7'h4B, 7'h3C, 7'h2D}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              pwr_good,
    input  logic              scl,
    input  logic              sda,
    input  logic [PAR_W-1:0]  par_vid,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_tgt,
    input  logic [BYTE_W-1:0] cmd_byte,
    output logic              listen,
    output logic [CODE_W-1:0] plane1_code,
    output logic [CODE_W-1:0] plane2_code,
    output logic              psi_low,
    output logic              serial_mode,
    output logic              plane2_hiz
);

    localparam ctl_t CTL_RST = '{
        en_q: 1'b0, serial_q: 1'b0, fixed_q: 1'b0, boot_q: 2'b00,
        listen_q: 1'b0, pg_q: 1'b0, p1: '0, p2: '0, psi: 1'b1, hiz: 1'b1
    };

    ctl_t q, d;

    logic [1:0]        pin_code;
    logic [CODE_W-1:0] par_code;
    logic [CODE_W-1:0] boot_val, fix_val, replay_val;

    always_comb begin
        pin_code   = {scl, sda};
        par_code   = {{(CODE_W-PAR_W){1'b0}}, par_vid};
        boot_val   = BOOT_TABLE[int'(pin_code)*CODE_W +: CODE_W];
        fix_val    = FIX_TABLE[int'(pin_code)*CODE_W +: CODE_W];
        replay_val = BOOT_TABLE[int'(q.boot_q)*CODE_W +: CODE_W];

        d = q;
        if (!enable) begin
            d = CTL_RST;
        end else if (!q.en_q) begin
            d.en_q     = 1'b1;
            d.pg_q     = pwr_good;
            d.listen_q = 1'b0;
            d.psi      = 1'b1;
            d.serial_q = ~par_vid[1];
            if (!par_vid[1]) begin
                d.fixed_q = pwr_good;
                d.hiz     = 1'b0;
                if (pwr_good) begin
                    d.p1 = fix_val;
                    d.p2 = fix_val;
                end else begin
                    d.boot_q = pin_code;
                    d.p1     = boot_val;
                    d.p2     = boot_val;
                end
            end else begin
                d.fixed_q = 1'b0;
                d.hiz     = 1'b1;
                d.p1      = par_code;
                d.p2      = '0;
            end
        end else begin
            d.pg_q = pwr_good;
            if (!q.serial_q) begin
                d.p1 = par_code;
            end else if (!q.fixed_q) begin
                d.listen_q = pwr_good;
                if (q.pg_q && !pwr_good) begin
                    d.p1  = replay_val;
                    d.p2  = replay_val;
                    d.psi = 1'b1;
                end else if (cmd_valid && q.listen_q) begin
                    d.psi = cmd_byte[BYTE_W-1];
                    if (cmd_tgt[0]) d.p1 = cmd_byte[CODE_W-1:0];
                    if (cmd_tgt[1]) d.p2 = cmd_byte[CODE_W-1:0];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= CTL_RST;
        else        q <= d;
    end

    assign listen      = q.listen_q;
    assign plane1_code = q.p1;
    assign plane2_code = q.p2;
    assign psi_low     = q.psi;
    assign serial_mode = q.serial_q;
    assign plane2_hiz  = q.hiz;

endmodule

// File: rtl/svid_ctrl.sv
module svid_ctrl
    import svid_pkg::*;
#(
    parameter int                          PAR_W       = 6,
    parameter logic [BYTE_W-SEL_W-1:0]     ADDR_PREFIX = 5'b11000,
    parameter logic [SEL_W-1:0]            SEL_P1      = 3'b110,
    parameter logic [SEL_W-1:0]            SEL_P2      = 3'b101,
    parameter logic [SEL_W-1:0]            SEL_BOTH    = 3'b111,
    parameter logic [4*CODE_W-1:0]         BOOT_TABLE  = {7'h48, 7'h36, 7'h24, 7'h12},
    parameter logic [4*CODE_W-1:0]         FIX_TABLE   = {7'h5A, 7'h4B, 7'h3C, 7'h2D}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              pwr_good,
    input  logic              scl,
    input  logic              sda,
    input  logic [PAR_W-1:0]  par_vid,
    output logic              sda_pull_low,
    output logic [CODE_W-1:0] plane1_code,
    output logic [CODE_W-1:0] plane2_code,
    output logic              psi_low,
    output logic              serial_mode,
    output logic              plane2_hiz
);

    logic              listen;
    logic              cmd_valid;
    logic [1:0]        cmd_tgt;
    logic [BYTE_W-1:0] cmd_byte;

    svid_link_rx #(
        .ADDR_PREFIX (ADDR_PREFIX),
        .SEL_P1      (SEL_P1),
        .SEL_P2      (SEL_P2),
        .SEL_BOTH    (SEL_BOTH)
    ) u_rx (
        .clk          (clk),
        .rst_n        (rst_n),
        .active       (listen),
        .scl          (scl),
        .sda          (sda),
        .sda_pull_low (sda_pull_low),
        .cmd_valid    (cmd_valid),
        .cmd_tgt      (cmd_tgt),
        .cmd_byte     (cmd_byte)
    );

    svid_plane_ctrl #(
        .PAR_W      (PAR_W),
        .BOOT_TABLE (BOOT_TABLE),
        .FIX_TABLE  (FIX_TABLE)
    ) u_ctl (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (enable),
        .pwr_good    (pwr_good),
        .scl         (scl),
        .sda         (sda),
        .par_vid     (par_vid),
        .cmd_valid   (cmd_valid),
        .cmd_tgt     (cmd_tgt),
        .cmd_byte    (cmd_byte),
        .listen      (listen),
        .plane1_code (plane1_code),
        .plane2_code (plane2_code),
        .psi_low     (psi_low),
        .serial_mode (serial_mode),
        .plane2_hiz  (plane2_hiz)
    );

endmodule

// File: rtl/svid_ctrl_chk.sv
module svid_ctrl_chk #(
    parameter int CW = 7
) (
    input logic          clk,
    input logic          rst_n,
    input logic          enable,
    input logic          pwr_good,
    input logic          scl,
    input logic          sda_pull_low,
    input logic [CW-1:0] plane1_code,
    input logic [CW-1:0] plane2_code,
    input logic          psi_low,
    input logic          serial_mode,
    input logic          plane2_hiz
);

    // R1
    disabled_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (plane1_code == '0 && plane2_code == '0 && plane2_hiz
                     && psi_low && !serial_mode && !sda_pull_low));

    // R2
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && $past(enable) && $past(enable, 2)) |-> $stable(serial_mode));

    // R3
    parallel_plane2_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !serial_mode |-> (plane2_code == '0 && plane2_hiz));

    // R4
    serial_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        serial_mode |-> !plane2_hiz);

    // R6
    quiet_before_pg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwr_good && $past(!pwr_good) && $past(!pwr_good, 2)) |-> !sda_pull_low);

    // R8
    ack_on_low_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull_low) |-> !scl);

endmodule

bind svid_ctrl svid_ctrl_chk #(.CW(svid_pkg::CODE_W)) u_svid_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .enable       (enable),
    .pwr_good     (pwr_good),
    .scl          (scl),
    .sda_pull_low (sda_pull_low),
    .plane1_code  (plane1_code),
    .plane2_code  (plane2_code),
    .psi_low      (psi_low),
    .serial_mode  (serial_mode),
    .plane2_hiz   (plane2_hiz)
);

// File: tb/tb_svid_ctrl.sv
module tb_svid_ctrl;

    localparam logic [6:0] BOOT_V [4] = '{7'h12, 7'h24, 7'h36, 7'h48};
    localparam logic [6:0] FIX_V  [4] = '{7'h2D, 7'h3C, 7'h4B, 7'h5A};

    logic       clk = 1'b0;
    logic       rst_n, enable, pwr_good, scl, sda_b;
    logic [5:0] par_vid;
    logic       sda_line;
    logic       sda_pull_low, psi_low, serial_mode, plane2_hiz;
    logic [6:0] plane1_code, plane2_code;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 1'b0;

    always #5 clk = ~clk;

    assign sda_line = sda_b & ~sda_pull_low;

    svid_ctrl dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .enable       (enable),
        .pwr_good     (pwr_good),
        .scl          (scl),
        .sda          (sda_line),
        .par_vid      (par_vid),
        .sda_pull_low (sda_pull_low),
        .plane1_code  (plane1_code),
        .plane2_code  (plane2_code),
        .psi_low      (psi_low),
        .serial_mode  (serial_mode),
        .plane2_hiz   (plane2_hiz)
    );

    // ---------------- behavioural reference model ----------------
    int m_p1, m_p2, m_psi, m_mode, m_hiz, m_ack;
    int m_en, m_fixed, m_boot, m_listen, m_pgp, m_sclp, m_sdap;
    int m_phase, m_cnt, m_sh, m_tgt, m_cmdv, m_cmd_sh, m_cmd_tgt;

    task automatic model_reset();
        m_p1 = 0; m_p2 = 0; m_psi = 1; m_mode = 0; m_hiz = 1; m_ack = 0;
        m_en = 0; m_fixed = 0; m_boot = 0; m_listen = 0; m_pgp = 0;
        m_phase = 0; m_cnt = 0; m_sh = 0; m_tgt = 0; m_cmdv = 0;
        m_cmd_sh = 0; m_cmd_tgt = 0;
    endtask

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            model_reset();
            m_sclp = 1; m_sdap = 1;
        end else begin
            int rise, fall, st, sp, line, pend, sel, v;
            line = int'(sda_line);
            rise = (scl && !m_sclp);
            fall = (!scl && m_sclp);
            st   = (scl && m_sclp && m_sdap && !line);
            sp   = (scl && m_sclp && !m_sdap && line);
            pend = 0;
            // receiver
            if (!m_listen) begin
                m_phase = 0; m_ack = 0;
            end else if (st) begin
                m_phase = 1; m_cnt = 0; m_ack = 0;
            end else if (sp) begin
                m_phase = 0; m_ack = 0;
            end else if (m_phase == 1 && rise) begin
                m_sh = ((m_sh << 1) | line) & 255;
                m_cnt++;
                if (m_cnt == 8) begin
                    sel = m_sh & 7;
                    if ((m_sh >> 3) == 5'b11000 && (sel == 6 || sel == 5 || sel == 7)) begin
                        m_tgt = (sel == 6) ? 1 : (sel == 5) ? 2 : 3;
                        m_phase = 2;
                    end else m_phase = 0;
                end
            end else if (m_phase == 2 && fall) begin
                if (!m_ack) m_ack = 1;
                else begin m_ack = 0; m_phase = 3; m_cnt = 0; end
            end else if (m_phase == 3 && rise) begin
                m_sh = ((m_sh << 1) | line) & 255;
                m_cnt++;
                if (m_cnt == 8) m_phase = 4;
            end else if (m_phase == 4) begin
                if (fall && !m_ack) m_ack = 1;
                else if (rise && m_ack) pend = 1;
                else if (fall && m_ack) begin m_ack = 0; m_phase = 5; end
            end
            // controller
            if (!enable) begin
                m_p1 = 0; m_p2 = 0; m_psi = 1; m_mode = 0; m_hiz = 1;
                m_en = 0; m_fixed = 0; m_boot = 0; m_listen = 0; m_pgp = 0;
            end else if (!m_en) begin
                m_en = 1; m_pgp = pwr_good; m_listen = 0; m_psi = 1;
                v = scl * 2 + line;
                if (!par_vid[1]) begin
                    m_mode = 1; m_hiz = 0; m_fixed = pwr_good;
                    if (pwr_good) begin m_p1 = FIX_V[v]; m_p2 = FIX_V[v]; end
                    else begin m_boot = v; m_p1 = BOOT_V[v]; m_p2 = BOOT_V[v]; end
                end else begin
                    m_mode = 0; m_hiz = 1; m_fixed = 0; m_p1 = par_vid; m_p2 = 0;
                end
            end else begin
                if (!m_mode) m_p1 = par_vid;
                else if (!m_fixed) begin
                    if (m_pgp && !pwr_good) begin
                        m_p1 = BOOT_V[m_boot]; m_p2 = BOOT_V[m_boot]; m_psi = 1;
                    end else if (m_cmdv && m_listen) begin
                        m_psi = (m_cmd_sh >> 7) & 1;
                        if (m_cmd_tgt & 1) m_p1 = m_cmd_sh & 127;
                        if (m_cmd_tgt & 2) m_p2 = m_cmd_sh & 127;
                    end
                    m_listen = pwr_good;
                end
                m_pgp = pwr_good;
            end
            m_cmdv = pend; m_cmd_sh = m_sh; m_cmd_tgt = m_tgt;
            m_sclp = scl; m_sdap = line;
        end
    end

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            n_tests++;
            if (int'(plane1_code) != m_p1) begin n_fail++;
                $display("FAIL R10 model plane1 actual=%0h expected=%0h", plane1_code, m_p1); end
            if (int'(plane2_code) != m_p2) begin n_fail++;
                $display("FAIL R10 model plane2 actual=%0h expected=%0h", plane2_code, m_p2); end
            if (int'(psi_low) != m_psi) begin n_fail++;
                $display("FAIL R10 model psi_low actual=%0d expected=%0d", psi_low, m_psi); end
            if (int'(serial_mode) != m_mode) begin n_fail++;
                $display("FAIL R2 model serial_mode actual=%0d expected=%0d", serial_mode, m_mode); end
            if (int'(plane2_hiz) != m_hiz) begin n_fail++;
                $display("FAIL R3 model plane2_hiz actual=%0d expected=%0d", plane2_hiz, m_hiz); end
            if (int'(sda_pull_low) != m_ack) begin n_fail++;
                $display("FAIL R8 model ack actual=%0d expected=%0d", sda_pull_low, m_ack); end
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_start();
        sda_b = 1'b1; scl = 1'b1; tick(2);
        sda_b = 1'b0; tick(4);
        scl = 1'b0; tick(2);
    endtask

    task automatic bus_stop();
        sda_b = 1'b0; tick(2);
        scl = 1'b1; tick(4);
        sda_b = 1'b1; tick(4);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            sda_b = b[i]; tick(2);
            scl = 1'b1; tick(4);
            scl = 1'b0; tick(2);
        end
    endtask

    task automatic ack_clock(output logic got);
        sda_b = 1'b1; tick(2);
        scl = 1'b1; tick(2);
        got = sda_pull_low; tick(2);
        scl = 1'b0; tick(2);
    endtask

    task automatic frame(input logic [7:0] addr, input logic [7:0] data,
                         output logic a1, output logic a2);
        bus_start();
        send_bits(addr, 8); ack_clock(a1);
        send_bits(data, 8); ack_clock(a2);
        bus_stop();
        tick(4);
    endtask

    // ---------------- main sequence ----------------
    initial begin
        logic a1, a2;
        rst_n = 1'b0; enable = 1'b0; pwr_good = 1'b0;
        scl = 1'b1; sda_b = 1'b1; par_vid = '0;
        tick(5);
        // R1 reset / disabled state
        check("R1 plane1 after reset", plane1_code, 0);
        check("R1 hiz after reset", plane2_hiz, 1);
        check("R1 psi after reset", psi_low, 1);
        rst_n = 1'b1; tick(3);

        // parallel mode
        par_vid = 6'b101010; tick(1);
        enable = 1'b1; tick(3);
        check("R2 parallel mode flag", serial_mode, 0);
        check("R3 plane1 follows pins", plane1_code, 7'h2A);
        check("R3 plane2 floated", plane2_hiz, 1);
        par_vid = 6'b000101; tick(3);
        check("R2 mode held after pin change", serial_mode, 0);
        check("R3 plane1 tracks new pins", plane1_code, 7'h05);
        pwr_good = 1'b1; tick(3);
        frame(8'hC6, 8'h15, a1, a2);
        check("R3 no ack in parallel mode", a1, 0);
        enable = 1'b0; pwr_good = 1'b0; tick(3);
        check("R1 disabled plane1", plane1_code, 0);
        check("R1 disabled mode", serial_mode, 0);

        // serial boot mode, boot code 2
        par_vid = 6'b000000; scl = 1'b1; sda_b = 1'b0; tick(2);
        enable = 1'b1; tick(3);
        sda_b = 1'b1; tick(3);
        check("R2 serial mode flag", serial_mode, 1);
        check("R4 boot plane1", plane1_code, BOOT_V[2]);
        check("R4 boot plane2", plane2_code, BOOT_V[2]);
        check("R4 plane2 driven", plane2_hiz, 0);
        par_vid = 6'b000010; tick(3);
        check("R2 mode held in serial", serial_mode, 1);

        frame(8'hC6, 8'h15, a1, a2);
        check("R6 no ack before power-good", a1, 0);
        check("R6 plane1 unchanged", plane1_code, BOOT_V[2]);

        pwr_good = 1'b1; tick(4);
        frame(8'hC6, 8'h15, a1, a2);
        check("R8 address ack", a1, 1);
        check("R8 data ack", a2, 1);
        check("R9 plane1 written", plane1_code, 7'h15);
        check("R9 plane2 untouched", plane2_code, BOOT_V[2]);
        check("R10 psi cleared", psi_low, 0);

        frame(8'hC5, 8'hB3, a1, a2);
        check("R9 plane2 written", plane2_code, 7'h33);
        check("R9 plane1 kept", plane1_code, 7'h15);
        check("R10 psi set", psi_low, 1);

        frame(8'hC7, 8'h44, a1, a2);
        check("R9 both plane1", plane1_code, 7'h44);
        check("R9 both plane2", plane2_code, 7'h44);
        check("R10 psi from both", psi_low, 0);

        frame(8'hC4, 8'h7F, a1, a2);
        check("R9 bad select no ack", a1, 0);
        check("R9 bad select no change", plane1_code, 7'h44);
        frame(8'hA6, 8'h7F, a1, a2);
        check("R9 bad prefix no ack", a1, 0);
        check("R9 bad prefix no change", plane2_code, 7'h44);

        // R11 cut-short frame
        bus_start();
        send_bits(8'hC7, 8); ack_clock(a1);
        send_bits(8'h9A, 5);
        bus_stop(); tick(4);
        check("R11 partial ack seen", a1, 1);
        check("R11 plane1 unchanged", plane1_code, 7'h44);
        check("R11 psi unchanged", psi_low, 0);

        // R5 power-good drop
        pwr_good = 1'b0; tick(3);
        check("R5 replay plane1", plane1_code, BOOT_V[2]);
        check("R5 replay plane2", plane2_code, BOOT_V[2]);
        check("R5 psi restored", psi_low, 1);
        pwr_good = 1'b1; tick(4);
        frame(8'hC6, 8'h21, a1, a2);
        check("R8 ack after re-power", a2, 1);
        check("R10 plane1 after re-power", plane1_code, 7'h21);
        enable = 1'b0; pwr_good = 1'b0; tick(3);

        // boot code 1
        scl = 1'b0; sda_b = 1'b1; par_vid = '0; tick(2);
        enable = 1'b1; tick(3);
        scl = 1'b1; tick(3);
        check("R4 boot code 1 plane1", plane1_code, BOOT_V[1]);
        check("R4 boot code 1 plane2", plane2_code, BOOT_V[1]);
        enable = 1'b0; tick(3);

        // fixed mode, code 3
        pwr_good = 1'b1; scl = 1'b1; sda_b = 1'b1; tick(2);
        enable = 1'b1; tick(4);
        check("R7 fixed plane1", plane1_code, FIX_V[3]);
        check("R7 fixed plane2", plane2_code, FIX_V[3]);
        check("R7 fixed serial flag", serial_mode, 1);
        frame(8'hC7, 8'h11, a1, a2);
        check("R7 no ack in fixed mode", a1, 0);
        check("R7 fixed ignores bus", plane1_code, FIX_V[3]);
        pwr_good = 1'b0; tick(4);
        check("R7 no replay in fixed mode", plane2_code, FIX_V[3]);
        enable = 1'b0; tick(3);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_tests++; n_fail++;
            $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule